// File: doc/BRIEF.md
# Nonvolatile Memory Write Controller

This block sequences read, erase and program operations on two behavioural nonvolatile arrays. One is a 16-bit program memory, which also holds a small configuration space. The other is a byte-wide data memory. Software drives it through a single-cycle register bus with three registers: control, address and data. Software picks the target space, sets the mode bits and the program/erase enable, and then sets a start bit. Hardware clears the start bits itself. Erase and program phases are timed by an internal counter whose lengths are parameters.

Program memory is written a row at a time through a row of 16 write latches. Software can fill latches in latch-only mode, then issue one committing write that programs the whole row. The data memory always runs an erase phase followed by a program phase on every write. An error flag records writes attempted without the enable bit and operations cut short by a reset or by clearing the enable bit.

No data stream crosses the block's edge. Every register access completes in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. Software polls `busy`, or the write-start bit, before it issues the next operation.

Top module: `nvm_write_ctrl`

## Requirements
- R1: Register 0 is control: bit0 write start, bit1 read start, bit2 program/erase enable, bit3 erase mode, bit4 latch-only, bit5 error flag, bit6 program-memory select (1 program memory, 0 data memory), bit7 configuration select (1 redirects to configuration space whatever bit6 holds). Register 1 is address and register 2 is data. `reg_rdata` shows the addressed register in the same cycle. After reset, control, address, data, `busy`, `err` and both strobes are 0.
- R2: Writing 1 to read start sets the bit. One clock later the data register holds the addressed word, or the data byte zero-extended, and read start reads 0. Writing 0 to the bit has no effect.
- R3: Write start can only be set by software, and writing 0 to it while busy does not clear it. Hardware clears it when the operation ends. `busy` equals write start.
- R4: A program-memory write with latch-only 1 and erase mode 0 loads the data word into latch address[3:0] and is busy for 1 cycle. The array is not changed.
- R5: A program-memory write with latch-only 0 and erase mode 0 loads the latch and is busy for PROG_CYC cycles. It then overwrites the whole 16-word row with the latches, so latches that were not loaded write 0xFFFF. The latches then return to 0xFFFF.
- R6: A program-memory write with erase mode 1 overrides latch-only. It is busy for ERASE_CYC cycles, sets the row to 0xFFFF, and then hardware clears erase mode.
- R7: A data-memory write ignores latch-only and erase mode. It is busy for ERASE_CYC+PROG_CYC cycles, writes data[7:0], and leaves erase mode as software set it.
- R8: Setting write start with the enable bit written as 0 starts nothing, leaves both arrays unchanged and sets the error flag.
- R9: Writing control with the enable bit 0 while busy stops the operation at once, clears write start and sets the error flag. A data byte aborted during its erase phase keeps its old value.
- R10: A reset while busy sets the error flag, and a reset while idle clears it. Otherwise only a control write with bit5 = 0 clears it.
- R11: While busy, writes to the address register, the data register and the select, latch-only and erase-mode bits are ignored.
- R12: `erase_pulse` and `prog_pulse` are single-cycle strobes in the last cycle of each erase or program phase, never both at once. A commit gives one program strobe, a row erase one erase strobe, and a data write one of each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 address, 2 data) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Addressed register contents |
| busy | output | 1 | Erase, program or latch load in progress |
| err | output | 1 | Error flag |
| erase_pulse | output | 1 | Erase phase commit strobe |
| prog_pulse | output | 1 | Program phase commit strobe |

## Verification
The assertions check the following on every cycle:
- read start never stays set for two cycles;
- write start rises only from a software write;
- no strobe fires without the enable bit, and the two strobes never fire together;
- the phase counter stays below its limit;
- erase mode is cleared after a program-memory erase;
- the error flag falls only on a software clear;
- the mode, address and data registers hold still while busy.

Some behaviour only the directed scenarios can show, because it depends on array contents and on exact cycle counts:
- which row words a commit writes;
- that latch-only leaves the array untouched;
- the configuration redirect;
- the combined erase-then-write on data memory;
- the cycle length of each operation;
- that an aborted data write keeps the old byte.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int B_WR   = 0;
  localparam int B_RD   = 1;
  localparam int B_WREN = 2;
  localparam int B_ERS  = 3;
  localparam int B_LWO  = 4;
  localparam int B_ERR  = 5;
  localparam int B_PM   = 6;
  localparam int B_CFG  = 7;

  typedef enum logic [1:0] {
    OP_LATCH  = 2'd0,
    OP_COMMIT = 2'd1,
    OP_ERASE  = 2'd2,
    OP_DATA   = 2'd3
  } nvm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_ERASE = 2'd2,
    ST_PROG  = 2'd3
  } nvm_state_e;
endpackage

// File: rtl/nvm_latch_row.sv
module nvm_latch_row #(
  parameter int WORDS = 16,
  parameter int W     = 16,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [IW-1:0]      load_idx,
  input  logic [W-1:0]       load_data,
  input  logic               clear,
  output logic [WORDS*W-1:0] row_out
);
  for (genvar g = 0; g < WORDS; g++) begin : g_latch
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n || clear) q <= '1;
      else if (load && load_idx == IW'(g)) q <= load_data;
    end
    assign row_out[g*W +: W] = q;
  end

  // R5
  load_clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && clear));
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int W     = 16,
  parameter int DEPTH = 288,
  parameter int ROW   = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    idx,
  output logic [W-1:0]     rd_data,
  input  logic             erase_stb,
  input  logic             prog_stb,
  input  logic [ROW*W-1:0] wr_row
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] base;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  assign base    = idx & ~AW'(ROW - 1);
  assign rd_data = mem[idx];

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROW; r++) begin
      if (erase_stb)     mem[base + AW'(r)] <= '1;
      else if (prog_stb) mem[base + AW'(r)] <= wr_row[r*W +: W];
    end
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk) !(erase_stb && prog_stb));
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_pkg::*;
#(
  parameter int ERASE_CYC = 8,
  parameter int PROG_CYC  = 4,
  localparam int MAXC     = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CW       = $clog2(MAXC + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  nvm_op_e op_in,
  input  logic    abort,
  output nvm_op_e op_q,
  output logic    erase_stb,
  output logic    prog_stb,
  output logic    done
);
  nvm_state_e state;
  logic [CW-1:0] cnt;
  logic erase_last, prog_last;

  assign erase_last = (state == ST_ERASE) && (cnt == CW'(ERASE_CYC - 1));
  assign prog_last  = (state == ST_PROG)  && (cnt == CW'(PROG_CYC - 1));
  assign erase_stb  = erase_last && !abort;
  assign prog_stb   = prog_last && !abort;
  assign done       = (state == ST_LOAD) || (erase_stb && op_q != OP_DATA) || prog_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      op_q  <= OP_LATCH;
    end else if (abort) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          op_q <= op_in;
          cnt  <= '0;
          unique case (op_in)
            OP_LATCH:  state <= ST_LOAD;
            OP_COMMIT: state <= ST_PROG;
            default:   state <= ST_ERASE;
          endcase
        end
        ST_LOAD: state <= ST_IDLE;
        ST_ERASE: if (erase_last) begin
          cnt   <= '0;
          state <= (op_q == OP_DATA) ? ST_PROG : ST_IDLE;
        end else cnt <= cnt + 1'b1;
        ST_PROG: if (prog_last) begin
          cnt   <= '0;
          state <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  erase_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE) |-> (cnt < CW'(ERASE_CYC)));
  // R3
  prog_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG) |-> (cnt < CW'(PROG_CYC)));
  // R12
  erase_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_stb && op_q != OP_DATA) |=> (state == ST_IDLE));
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PM_WORDS  = 256,
  parameter int CFG_WORDS = 32,
  parameter int DM_BYTES  = 256,
  parameter int ROW_WORDS = 16,
  parameter int ERASE_CYC = 8,
  parameter int PROG_CYC  = 4,
  localparam int FL_DEPTH = PM_WORDS + CFG_WORDS,
  localparam int FL_AW    = $clog2(FL_DEPTH),
  localparam int PM_AW    = $clog2(PM_WORDS),
  localparam int CFG_AW   = $clog2(CFG_WORDS),
  localparam int DM_AW    = $clog2(DM_BYTES),
  localparam int LAT_AW   = $clog2(ROW_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        busy,
  output logic        err,
  output logic        erase_pulse,
  output logic        prog_pulse
);
  logic wr_go, rd_go, wr_en, erase_en, latch_only, pm_sel, cfg_sel;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0] data_q;

  logic ctrl_wr, start, abort, w_flash;
  nvm_op_e op_in, op_q;
  logic seq_erase, seq_prog, seq_done;
  logic op_flash, fl_erase, fl_prog, dm_erase, dm_prog;
  logic [FL_AW-1:0] fl_idx;
  logic [DM_AW-1:0] dm_idx;
  logic [15:0] fl_rd;
  logic [7:0]  dm_rd;
  logic [ROW_WORDS*16-1:0] row_data;

  assign ctrl_wr = reg_we && (reg_addr == 2'd0);
  assign w_flash = reg_wdata[B_PM] || reg_wdata[B_CFG];
  assign start   = ctrl_wr && !wr_go && reg_wdata[B_WR] && reg_wdata[B_WREN];
  assign abort   = ctrl_wr && wr_go && !reg_wdata[B_WREN];

  always_comb begin
    if (!w_flash)                op_in = OP_DATA;
    else if (reg_wdata[B_ERS])   op_in = OP_ERASE;
    else if (reg_wdata[B_LWO])   op_in = OP_LATCH;
    else                         op_in = OP_COMMIT;
  end

  nvm_seq #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in), .abort(abort),
    .op_q(op_q), .erase_stb(seq_erase), .prog_stb(seq_prog), .done(seq_done)
  );

  assign op_flash = (op_q != OP_DATA);
  assign fl_erase = seq_erase && op_flash;
  assign fl_prog  = seq_prog && op_flash;
  assign dm_erase = seq_erase && !op_flash;
  assign dm_prog  = seq_prog && !op_flash;

  assign fl_idx = cfg_sel ? (FL_AW'(PM_WORDS) + FL_AW'(addr_q[CFG_AW-1:0]))
                          : FL_AW'(addr_q[PM_AW-1:0]);
  assign dm_idx = addr_q[DM_AW-1:0];

  nvm_latch_row #(.WORDS(ROW_WORDS), .W(16)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .load(start && w_flash && !reg_wdata[B_ERS]),
    .load_idx(addr_q[LAT_AW-1:0]), .load_data(data_q),
    .clear(fl_prog), .row_out(row_data)
  );

  nvm_array #(.W(16), .DEPTH(FL_DEPTH), .ROW(ROW_WORDS)) u_flash (
    .clk(clk), .idx(fl_idx), .rd_data(fl_rd),
    .erase_stb(fl_erase), .prog_stb(fl_prog), .wr_row(row_data)
  );

  nvm_array #(.W(8), .DEPTH(DM_BYTES), .ROW(1)) u_data (
    .clk(clk), .idx(dm_idx), .rd_data(dm_rd),
    .erase_stb(dm_erase), .prog_stb(dm_prog), .wr_row(data_q[7:0])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err        <= wr_go;
      wr_go      <= 1'b0;
      rd_go      <= 1'b0;
      wr_en      <= 1'b0;
      erase_en   <= 1'b0;
      latch_only <= 1'b0;
      pm_sel     <= 1'b0;
      cfg_sel    <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
    end else begin
      if (rd_go) begin
        data_q <= (pm_sel || cfg_sel) ? fl_rd : {8'h00, dm_rd};
        rd_go  <= 1'b0;
      end
      if (seq_done) wr_go <= 1'b0;
      if (fl_erase) erase_en <= 1'b0;
      if (ctrl_wr) begin
        if (wr_go) begin
          if (!reg_wdata[B_WREN]) begin
            wr_go <= 1'b0;
            wr_en <= 1'b0;
            err   <= 1'b1;
          end else if (!reg_wdata[B_ERR]) err <= 1'b0;
        end else begin
          wr_en      <= reg_wdata[B_WREN];
          erase_en   <= reg_wdata[B_ERS];
          latch_only <= reg_wdata[B_LWO];
          pm_sel     <= reg_wdata[B_PM];
          cfg_sel    <= reg_wdata[B_CFG];
          if (!reg_wdata[B_ERR]) err <= 1'b0;
          if (reg_wdata[B_WR]) begin
            if (reg_wdata[B_WREN]) wr_go <= 1'b1;
            else                   err   <= 1'b1;
          end else if (reg_wdata[B_RD] && !rd_go) rd_go <= 1'b1;
        end
      end
      if (reg_we && !wr_go && reg_addr == 2'd1) addr_q <= reg_wdata[ADDR_W-1:0];
      if (reg_we && !wr_go && reg_addr == 2'd2) data_q <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      2'd0:    reg_rdata = {8'h00, cfg_sel, pm_sel, err, latch_only, erase_en, wr_en, rd_go, wr_go};
      2'd1:    reg_rdata = 16'(addr_q);
      2'd2:    reg_rdata = data_q;
      default: reg_rdata = '0;
    endcase
  end

  assign busy        = wr_go;
  assign erase_pulse = seq_erase;
  assign prog_pulse  = seq_prog;

  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go);
  // R3
  wr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_go) |-> $past(ctrl_wr && reg_wdata[B_WR]));
  // R8
  strobe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_erase || seq_prog) |-> (wr_en && wr_go));
  // R6
  erase_en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |=> !erase_en);
  // R10
  err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(err)) |-> $past(ctrl_wr && !reg_wdata[B_ERR]));
  // R11
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_go)) |->
      ($stable(pm_sel) && $stable(cfg_sel) && $stable(latch_only) && $stable(addr_q)));
endmodule

// File: tb/test_nvm_write_ctrl.sv
module test_nvm_write_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ERASE_CYC = 8;
  localparam int PROG_CYC  = 4;
  localparam logic [15:0] C_WR = 16'h0001, C_RD = 16'h0002, C_EN = 16'h0004,
    C_ERS = 16'h0008, C_LWO = 16'h0010, C_ERR = 16'h0020, C_PM = 16'h0040, C_CFG = 16'h0080;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic busy, err, erase_pulse, prog_pulse;
  int n_chk = 0, n_fail = 0;
  int n_busy, n_ers, n_prg;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_write_ctrl #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) i_nvm_write_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .err(err),
    .erase_pulse(erase_pulse), .prog_pulse(prog_pulse)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle();
    n_busy = 0; n_ers = 0; n_prg = 0;
    while (busy && n_busy < 100) begin
      n_busy++;
      if (erase_pulse) n_ers++;
      if (prog_pulse) n_prg++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(posedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic rd_mem(logic [7:0] a, logic [15:0] sel, output logic [15:0] v);
    logic [15:0] c;
    wr(2'd1, {8'h00, a});
    wr(2'd0, C_RD | sel);
    peek(2'd0, c);
    check("R2 read start set", c & C_RD, C_RD);
    @(negedge clk);
    peek(2'd0, c);
    check("R2 read start cleared", c & C_RD, 16'h0);
    peek(2'd2, v);
  endtask

  task automatic write_op(logic [7:0] a, logic [15:0] d, logic [15:0] c);
    wr(2'd1, {8'h00, a});
    wr(2'd2, d);
    wr(2'd0, c);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(2'd0, v); check("R1 ctrl reset", v, 16'h0);
    peek(2'd1, v); check("R1 addr reset", v, 16'h0);
    peek(2'd2, v); check("R1 data reset", v, 16'h0);
    check("R1 busy/err/strobes reset", {12'h0, busy, err, erase_pulse, prog_pulse}, 16'h0);
  endtask

  task automatic t_latch_commit();
    logic [15:0] v;
    write_op(8'h23, 16'h1234, C_WR | C_EN | C_LWO | C_PM);
    wait_idle();
    check("R4 latch-only busy cycles", 16'(n_busy), 16'd1);
    rd_mem(8'h23, C_PM, v);
    check("R4 array untouched", v, 16'hFFFF);
    write_op(8'h25, 16'hABCD, C_WR | C_EN | C_PM);
    wait_idle();
    check("R5 commit busy cycles", 16'(n_busy), 16'(PROG_CYC));
    check("R12 commit strobes", {8'(n_ers), 8'(n_prg)}, 16'h0001);
    rd_mem(8'h23, C_PM, v); check("R5 latched word", v, 16'h1234);
    rd_mem(8'h25, C_PM, v); check("R5 addressed word", v, 16'hABCD);
    rd_mem(8'h20, C_PM, v); check("R5 unloaded word", v, 16'hFFFF);
    write_op(8'h26, 16'h5555, C_WR | C_EN | C_PM);
    wait_idle();
    rd_mem(8'h23, C_PM, v); check("R5 latches reset after commit", v, 16'hFFFF);
    rd_mem(8'h26, C_PM, v); check("R5 second commit", v, 16'h5555);
  endtask

  task automatic t_erase();
    logic [15:0] v;
    write_op(8'h40, 16'h0F00, C_WR | C_EN | C_PM);
    wait_idle();
    write_op(8'h41, 16'h0000, C_WR | C_EN | C_ERS | C_LWO | C_PM);
    wait_idle();
    check("R6 erase busy cycles", 16'(n_busy), 16'(ERASE_CYC));
    check("R12 erase strobes", {8'(n_ers), 8'(n_prg)}, 16'h0100);
    peek(2'd0, v); check("R6 erase mode cleared", v & C_ERS, 16'h0);
    rd_mem(8'h40, C_PM, v); check("R6 row erased", v, 16'hFFFF);
  endtask

  task automatic t_cfg();
    logic [15:0] v;
    write_op(8'h03, 16'h0F0F, C_WR | C_EN | C_PM | C_CFG);
    wait_idle();
    rd_mem(8'h03, C_PM, v); check("R1 program space not hit", v, 16'hFFFF);
    rd_mem(8'h03, C_CFG, v); check("R1 config space word", v, 16'h0F0F);
  endtask

  task automatic t_data();
    logic [15:0] v;
    write_op(8'h10, 16'h77A5, C_WR | C_EN | C_ERS | C_LWO);
    wait_idle();
    check("R7 data busy cycles", 16'(n_busy), 16'(ERASE_CYC + PROG_CYC));
    check("R12 data strobes", {8'(n_ers), 8'(n_prg)}, 16'h0101);
    peek(2'd0, v); check("R7 erase mode kept", v & C_ERS, C_ERS);
    rd_mem(8'h10, 16'h0, v); check("R7 data byte", v, 16'h00A5);
  endtask

  task automatic t_inhibit();
    logic [15:0] v;
    write_op(8'h11, 16'h0033, C_WR);
    check("R8 no busy", {15'h0, busy}, 16'h0);
    check("R8 err set", {15'h0, err}, 16'h1);
    rd_mem(8'h11, C_ERR, v); check("R8 array unchanged", v, 16'h00FF);
    check("R10 err held by write of 1", {15'h0, err}, 16'h1);
    wr(2'd0, 16'h0);
    check("R10 err software clear", {15'h0, err}, 16'h0);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    write_op(8'h12, 16'h0077, C_WR | C_EN);
    repeat (3) @(negedge clk);
    wr(2'd0, 16'h0);
    check("R9 busy dropped", {15'h0, busy}, 16'h0);
    check("R9 err set", {15'h0, err}, 16'h1);
    rd_mem(8'h12, C_ERR, v); check("R9 byte kept", v, 16'h00FF);
    wr(2'd0, 16'h0);
  endtask

  task automatic t_lock();
    logic [15:0] v;
    write_op(8'h13, 16'h0044, C_WR | C_EN);
    wr(2'd1, 16'h0050);
    wr(2'd2, 16'h0099);
    wr(2'd0, C_EN | C_PM | C_CFG | C_LWO);
    check("R3 write of 0 keeps busy", {15'h0, busy}, 16'h1);
    wait_idle();
    peek(2'd0, v); check("R11 selects kept", v & (C_PM | C_CFG | C_LWO), 16'h0);
    peek(2'd1, v); check("R11 address kept", v, 16'h0013);
    rd_mem(8'h13, 16'h0, v); check("R11 data kept", v, 16'h0044);
  endtask

  task automatic t_reset_mid();
    logic [15:0] v;
    write_op(8'h14, 16'h0066, C_WR | C_EN);
    repeat (2) @(negedge clk);
    do_reset();
    check("R10 err after reset mid-op", {14'h0, busy, err}, 16'h1);
    rd_mem(8'h14, C_ERR, v); check("R10 byte kept", v, 16'h00FF);
    do_reset();
    check("R10 err cleared by idle reset", {15'h0, err}, 16'h0);
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_reset();
        t_latch_commit();
        t_erase();
        t_cfg();
        t_data();
        t_inhibit();
        t_abort();
        t_lock();
        t_reset_mid();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule